// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block switches on a set of DC/DC converter modules in a controlled order once the main supply reports power-good. The first converter is switched directly by power-good. The block drives one enable output for each further converter stage. Each stage releases its enable after its own delay, set as a clock-cycle count on a configuration input. Every converter reports a voltage-good signal back. Each voltage-good input passes through a two-flop synchronizer before the block uses it.

There are two modes. In parallel mode, every stage delay counts from the start of the sequence. In relay mode, a stage counts only while the voltage-good of the rail ahead of it is high, so the rails come up in a chain. A host hold-off output stays high until power-good, every enable and every voltage-good are active and a settle period has then elapsed. A rising edge on the host restart input shuts everything off and runs the sequence again without removing the main supply.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, every bit of `rail_en` is 0 and `host_reset` is 1.
- R2: While `pwr_good` is low, `rail_en` stays all zero and `host_reset` stays 1, whatever the voltage-good inputs do.
- R3: In parallel mode (`relay_mode`=0), enable i rises on the (D_i+2)-th rising edge, counting the first edge that samples `pwr_good` high out of idle as edge 1. D_i is `stage_delay[8*i+7:8*i]`.
- R4: In relay mode (`relay_mode`=1), the delay counter of stage i advances only in cycles where synchronized `volt_good[i]` is high. Bit 0 belongs to the converter switched by power-good, and bit i+1 belongs to the rail of enable i. The enable rises on the edge that ends the (D_i+1)-th such cycle. A raised enable stays high until power-good drops or a restart occurs.
- R5: A stage delay of 0 raises the enable on the edge that ends the first cycle in which the stage may count.
- R6: `host_reset` falls exactly WAIT_CYCLES+1 edges after the first edge that sees every enable high and every synchronized voltage-good high. Whenever `host_reset` is 0, every enable is 1.
- R7: If a synchronized voltage-good falls while `host_reset` is 0, `host_reset` rises on the next edge and the enables stay on. When all voltage-good inputs are good again, the settle period reruns.
- R8: On the edge that samples `pwr_good` low, all enables clear and `host_reset` rises, from any state.
- R9: On the edge that samples a rising edge of `host_restart`, all enables clear and `host_reset` rises. While the input stays high the block stays idle, and the sequence restarts on the first edge that samples it low again with `pwr_good` high.
- R10: A change on `volt_good` becomes visible to the sequencer two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Main supply good, synchronous to clk |
| relay_mode | input | 1 | 1 selects chained (relay) timing, 0 selects parallel timing |
| host_restart | input | 1 | Host resequence request, acts on its rising edge |
| stage_delay | input | N_STAGES*DLY_W | Per-stage delay in cycles, stage i in bits [DLY_W*i +: DLY_W] |
| volt_good | input | N_STAGES+1 | Voltage-good of each converter, bit 0 for the rail switched by power-good |
| rail_en | output | N_STAGES | Converter enables |
| host_reset | output | 1 | High holds the host in reset until all rails are good and settled |

## Verification
Parallel mode is run with mixed delays, including zero, while all voltage-good inputs are already high. This separates the counting of delays from power-good from any dependence on the rails. Relay mode is run first with the first rail held bad and then released, which shows whether a stage waits for its predecessor and whether the synchronizer adds its two cycles. Directed drops of one voltage-good, of power-good and of a held restart pulse separate the paths that only reassert the hold-off from those that also clear the enables. A long constrained-random phase adds a plant that raises each voltage-good some random time after its enable, plus occasional glitches, supply drops, restarts and mode changes. Every output in every cycle is compared against a bench reference model.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READY = 2'd3
    } rseq_state_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rseq_stage.sv
module rseq_stage #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             arm,
    input  logic [DLY_W-1:0] delay,
    output logic             en
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             en;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (clear) begin
            stage_d = '0;
        end else if (arm && !stage_q.en) begin
            if (stage_q.cnt == delay) stage_d.en  = 1'b1;
            else                      stage_d.cnt = stage_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign en = stage_q.en;

    // R4: once raised, an enable only falls through a clear
    assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.en && !clear) |=> stage_q.en);

    // R4: an enable cannot rise in a cycle where the stage may not count
    assert_enable_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_q.en && !arm) |=> !stage_q.en);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int N_STAGES    = 4,
    parameter int DLY_W       = 8,
    parameter int WAIT_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_good,
    input  logic                      relay_mode,
    input  logic                      host_restart,
    input  logic [N_STAGES*DLY_W-1:0] stage_delay,
    input  logic [N_STAGES:0]         volt_good,
    output logic [N_STAGES-1:0]       rail_en,
    output logic                      host_reset
);
    localparam int WW = $clog2(WAIT_CYCLES + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_CYCLES);

    typedef struct packed {
        rseq_state_e   st;
        logic [WW-1:0] wcnt;
        logic          hold;
        logic          rst_prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_STAGES:0]   vg_s;
    logic [N_STAGES-1:0] arm;
    logic                all_good;
    logic                restart_rise;
    logic                clear;

    rseq_sync #(.WIDTH(N_STAGES + 1), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (volt_good),
        .dout  (vg_s)
    );

    assign all_good     = &vg_s;
    assign restart_rise = host_restart & ~ctl_q.rst_prev;
    assign clear        = !pwr_good || restart_rise || (ctl_q.st == ST_IDLE);

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
            assign arm[g] = relay_mode ? vg_s[g] : 1'b1;
            rseq_stage #(.DLY_W(DLY_W)) i_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (clear),
                .arm   (arm[g]),
                .delay (stage_delay[g*DLY_W +: DLY_W]),
                .en    (rail_en[g])
            );
        end
    endgenerate

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rst_prev = host_restart;
        if (!pwr_good || restart_rise) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.wcnt = '0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (!host_restart) ctl_d.st = ST_SEQ;
                end
                ST_SEQ: begin
                    if ((&rail_en) && all_good) begin
                        ctl_d.st   = ST_WAIT;
                        ctl_d.wcnt = '0;
                    end
                end
                ST_WAIT: begin
                    if (!all_good)                 ctl_d.st   = ST_SEQ;
                    else if (ctl_q.wcnt == WAIT_LAST) ctl_d.st = ST_READY;
                    else                           ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                end
                ST_READY: begin
                    if (!all_good) begin
                        ctl_d.st   = ST_WAIT;
                        ctl_d.wcnt = '0;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
        ctl_d.hold = (ctl_d.st != ST_READY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st       <= ST_IDLE;
            ctl_q.wcnt     <= '0;
            ctl_q.hold     <= 1'b1;
            ctl_q.rst_prev <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_reset = ctl_q.hold;

    // R8: a supply drop clears everything on the next edge
    assert_supply_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (rail_en == '0 && host_reset));

    // R9: a restart edge clears everything on the next edge
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_rise |=> (rail_en == '0 && host_reset));

    // R6: the host is released only with every rail enabled
    assert_release_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_reset |-> (&rail_en));

    // R7: a rail going bad after release reasserts the hold-off
    assert_rail_loss_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_reset && !all_good && pwr_good) |=> (host_reset && (&rail_en)));
endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
    localparam int NS   = 4;
    localparam int DW   = 8;
    localparam int WAIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic relay_mode = 1'b0;
    logic host_restart = 1'b0;
    logic [NS*DW-1:0] stage_delay = '0;
    logic [NS:0] volt_good = '0;
    logic [NS-1:0] rail_en;
    logic host_reset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rail_sequencer #(.N_STAGES(NS), .DLY_W(DW), .WAIT_CYCLES(WAIT)) i_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .relay_mode(relay_mode),
        .host_restart(host_restart), .stage_delay(stage_delay),
        .volt_good(volt_good), .rail_en(rail_en), .host_reset(host_reset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dly(input int i);
        return int'(stage_delay[i*DW +: DW]);
    endfunction

    // reference model, written from the requirements (0 idle,1 seq,2 wait,3 ready)
    int m_st = 0, m_w = 0;
    int m_cnt [NS];
    bit [NS-1:0] m_en = '0;
    bit [NS:0] m_v1 = '0, m_v2 = '0;
    bit m_rp = 1'b0, m_hold = 1'b1, m_live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_w = 0; m_en = '0; m_v1 = '0; m_v2 = '0;
            m_rp = 1'b0; m_hold = 1'b1; m_live = 1'b1;
            for (int i = 0; i < NS; i++) m_cnt[i] = 0;
        end else begin
            bit rise, clr, good;
            bit [NS-1:0] en_old;
            int nst;
            rise = host_restart && !m_rp;
            clr = !pwr_good || rise || (m_st == 0);
            good = &m_v2;
            en_old = m_en;
            nst = m_st;
            if (!pwr_good || rise) begin nst = 0; m_w = 0; end
            else case (m_st)
                0: if (!host_restart) nst = 1;
                1: if ((&en_old) && good) begin nst = 2; m_w = 0; end
                2: if (!good) nst = 1; else if (m_w == WAIT) nst = 3; else m_w++;
                default: if (!good) begin nst = 2; m_w = 0; end
            endcase
            for (int i = 0; i < NS; i++) begin
                if (clr) begin m_cnt[i] = 0; m_en[i] = 1'b0; end
                else if ((!relay_mode || m_v2[i]) && !en_old[i]) begin
                    if (m_cnt[i] == dly(i)) m_en[i] = 1'b1; else m_cnt[i]++;
                end
            end
            m_st = nst;
            m_hold = (nst != 3);
            m_rp = host_restart;
            m_v2 = m_v1;
            m_v1 = volt_good;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk(rail_en == m_en, relay_mode ? "R4 enables vs model" : "R3 enables vs model",
                int'(rail_en), int'(m_en));
            chk(host_reset == m_hold, "R6 hold-off vs model", int'(host_reset), int'(m_hold));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int ep;
        void'($urandom(32'h5EC0_0A11));
        // R1: reset state
        cyc(3);
        chk(rail_en == '0, "R1 enables in reset", int'(rail_en), 0);
        chk(host_reset == 1'b1, "R1 hold-off in reset", int'(host_reset), 1);
        rst_n = 1'b1;
        volt_good = '1;
        stage_delay = {8'd1, 8'd5, 8'd3, 8'd0};
        // R2: no sequencing while power-good is low
        cyc(6);
        chk(rail_en == '0 && host_reset, "R2 idle while supply bad", int'(rail_en), 0);
        // R3 parallel timing, R5 zero delay
        pwr_good = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            cyc(1);
            for (int i = 0; i < NS; i++)
                chk(rail_en[i] == (k >= dly(i) + 2), i == 0 ? "R5 zero-delay stage" : "R3 parallel stage",
                    int'(rail_en[i]), int'(k >= dly(i) + 2));
        end
        // R6 settle period: all enables at edge 7, wait entered at edge 8
        for (int k = 11; k <= WAIT + 10; k++) begin
            cyc(1);
            chk(host_reset == (k < WAIT + 9), "R6 release timing", int'(host_reset), int'(k < WAIT + 9));
        end
        // R7 and R10: rail glitch after release
        volt_good[2] = 1'b0;
        cyc(2);
        chk(host_reset == 1'b0, "R10 glitch not yet seen", int'(host_reset), 0);
        cyc(1);
        chk(host_reset == 1'b1 && rail_en == '1, "R7 hold-off back, enables kept",
            int'({host_reset, rail_en}), int'({1'b1, 4'hF}));
        volt_good[2] = 1'b1;
        cyc(WAIT + 8);
        chk(host_reset == 1'b0 && rail_en == '1, "R7 re-release after settle",
            int'({host_reset, rail_en}), int'({1'b0, 4'hF}));
        // R9: held restart
        host_restart = 1'b1;
        cyc(1);
        chk(rail_en == '0 && host_reset, "R9 restart clears", int'(rail_en), 0);
        cyc(5);
        chk(rail_en == '0 && host_reset, "R9 idle while held", int'(rail_en), 0);
        host_restart = 1'b0;
        cyc(1);
        chk(rail_en == '0, "R9 first edge after release", int'(rail_en), 0);
        cyc(1);
        chk(rail_en[0] == 1'b1, "R9 sequence rerun", int'(rail_en[0]), 1);
        // R8: supply drop
        cyc(3);
        pwr_good = 1'b0;
        cyc(1);
        chk(rail_en == '0 && host_reset, "R8 supply drop clears", int'(rail_en), 0);
        // R4 relay: blocked, then released by first rail
        volt_good = '0;
        relay_mode = 1'b1;
        cyc(4);
        pwr_good = 1'b1;
        cyc(20);
        chk(rail_en == '0, "R4 relay waits for rail", int'(rail_en), 0);
        volt_good[0] = 1'b1;
        cyc(2);
        chk(rail_en[0] == 1'b0, "R4 synchronizer latency", int'(rail_en[0]), 0);
        cyc(1);
        chk(rail_en == 4'b0001, "R4 first stage only", int'(rail_en), 1);
        // random phase with a rail plant
        ep = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if ($urandom_range(499) == 0) begin
                pwr_good = 1'b0;
                relay_mode = $urandom_range(1);
                stage_delay = {8'($urandom_range(7)), 8'($urandom_range(7)),
                               8'($urandom_range(7)), 8'($urandom_range(7))};
                ep++;
            end else if (!pwr_good && $urandom_range(7) == 0) begin
                pwr_good = 1'b1;
            end
            host_restart = ($urandom_range(399) == 0) ? 1'b1 :
                           (host_restart && $urandom_range(3) != 0);
            for (int j = 0; j <= NS; j++) begin
                bit src;
                src = (j == 0) ? pwr_good : rail_en[j-1];
                if (!src) volt_good[j] = 1'b0;
                else if ($urandom_range(3) == 0) volt_good[j] = 1'b1;
            end
            if ($urandom_range(299) == 0) volt_good[$urandom_range(NS)] = 1'b0;
        end
        chk(ep > 0, "R8 random supply drops exercised", ep, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule